// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the timing signals for a master-mode audio serial link from a single kernel clock. A programmable linear divider divides the kernel clock by an integer ratio that is built from an 8-bit divide value and an extra odd bit. The divider output has a high phase that is at most one kernel cycle longer than its low phase, so odd ratios still give a usable square wave.

When the master-clock output is switched on, the divider output leaves the block as the master clock. The bit clock is then taken from the master clock through a fixed post-divider that depends on the channel length. This keeps the master clock at 256 times the sample rate for both channel lengths. When the master-clock output is switched off, the master-clock pin stays low and the bit clock is the divider output itself.

The block also produces a left/right word-select signal and a one-cycle strobe at the start of each frame. Configuration is sampled only while the block is disabled. Enabling the block starts every output from low, at the beginning of a left slot.

Top module: `audio_clkgen`

## Requirements
- R1: With the master clock off, the bit clock period equals N kernel cycles, where N = 2 × div_val + odd_ext (for div_val ≥ 2).
- R2: For an odd N, the divider output is high for (N+1)/2 kernel cycles and low for (N−1)/2 kernel cycles. For an even N, the two phases are equal.
- R3: A div_val of 0 or 1 gives N = 2 whatever odd_ext is, and cfg_err reads 1. For any div_val of 2 or more, cfg_err reads 0.
- R4: With mclk_en = 1, mclk has a period of N kernel cycles. bclk changes only as mclk falls, and the bclk period is 8 mclk periods when ch32 = 0 (16-bit channels) or 4 mclk periods when ch32 = 1 (32-bit channels).
- R5: With mclk_en = 0, mclk stays low and bclk is the divider output directly, with no post-division.
- R6: Word select is 0 for the left slot and 1 for the right slot. Each slot lasts L bit-clock periods, where L = 16 when ch32 = 0 and L = 32 when ch32 = 1.
- R7: Word select changes only in the kernel cycle in which bclk falls.
- R8: frame_pulse is high for exactly one kernel cycle, in the cycle in which ws falls back to 0. Consecutive pulses are 2 × L bit-clock periods apart, which is 256 × N kernel cycles when mclk_en = 1.
- R9: Changes to div_val, odd_ext, mclk_en and ch32 while enable = 1 have no effect on the outputs.
- R10: While enable = 0, mclk, bclk, ws and frame_pulse are low from the next kernel cycle onward. After enable rises, ws starts at 0 (a left slot).
- R11: While rst_n = 0, all outputs, including cfg_err, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; configuration is sampled while it is low |
| div_val | input | 8 | Linear divider value |
| odd_ext | input | 1 | Adds one kernel cycle to the divide ratio |
| mclk_en | input | 1 | Drives the master clock and turns on the bit-clock post-divider |
| ch32 | input | 1 | Channel length: 0 = 16 bits, 1 = 32 bits |
| mclk | output | 1 | Master clock |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select (0 = left, 1 = right) |
| frame_pulse | output | 1 | One-cycle strobe at each frame start |
| cfg_err | output | 1 | Sampled divide value is illegal (0 or 1) |

## Verification
The bench measures the period and high time of mclk and bclk, the word-select high time and the strobe spacing, over several patterns:

- An even ratio with 16-bit slots and an odd ratio with 32-bit slots, both with the master clock off. Together these separate the 2 × value + odd arithmetic from the uneven phase split.
- Both channel lengths with the master clock on. These show whether the post-divide of 8 or 4 is picked correctly while the frame length stays the same.
- Divide values 0 and 1, with the odd bit set. These show that the clamp to a ratio of 2 also ignores the odd bit.
- A divide value changed while the block runs. This shows that configuration is held while enabled.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int unsigned POST_MAX = 8;
  localparam int unsigned SLOT_MAX = 32;

  // Effective linear divide ratio; illegal values clamp to 2.
  function automatic int unsigned eff_ratio(int unsigned d, bit o);
    return (d < 2) ? 2 : (2 * d + (o ? 1 : 0));
  endfunction

  function automatic bit ratio_bad(int unsigned d);
    return d < 2;
  endfunction

  // Number of master-clock periods per bit-clock half period.
  function automatic int unsigned post_half(bit ch32);
    return ch32 ? 2 : 4;
  endfunction

  function automatic int unsigned slot_len(bit ch32);
    return ch32 ? 32 : 16;
  endfunction
endpackage

// File: rtl/acg_lindiv.sv
module acg_lindiv #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] ratio,
  output logic             lin,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] low_len;

  // Low phase is floor(N/2), high phase is the remainder.
  assign low_len = ratio >> 1;
  assign rise_ev = run && (cnt == low_len - 1'b1);
  assign fall_ev = run && (cnt == ratio - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lin <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      lin <= 1'b0;
    end else begin
      cnt <= fall_ev ? '0 : cnt + 1'b1;
      if (rise_ev)      lin <= 1'b1;
      else if (fall_ev) lin <= 1'b0;
    end
  end
endmodule

// File: rtl/acg_bitdiv.sv
module acg_bitdiv
  import acg_pkg::*;
#(
  parameter int PC_W = $clog2(POST_MAX)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic mck_mode,
  input  logic ch32,
  input  logic lin_rise,
  input  logic lin_fall,
  output logic bck,
  output logic bck_fall_ev
);
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] half;
  logic            bck_rise_ev;

  assign half = PC_W'(post_half(ch32));

  // With the master clock on, count its periods; otherwise pass the divider edges through.
  always_comb begin
    if (mck_mode) begin
      bck_rise_ev = lin_fall && (pc == half - 1'b1);
      bck_fall_ev = lin_fall && (pc == (half << 1) - 1'b1);
    end else begin
      bck_rise_ev = lin_rise;
      bck_fall_ev = lin_fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      bck <= 1'b0;
    end else if (!run) begin
      pc  <= '0;
      bck <= 1'b0;
    end else begin
      if (mck_mode && lin_fall)
        pc <= (pc == (half << 1) - 1'b1) ? '0 : pc + 1'b1;
      if (bck_rise_ev)      bck <= 1'b1;
      else if (bck_fall_ev) bck <= 1'b0;
    end
  end
endmodule

// File: rtl/acg_framer.sv
module acg_framer
  import acg_pkg::*;
#(
  parameter int BC_W = $clog2(SLOT_MAX)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ch32,
  input  logic bck_fall_ev,
  output logic ws,
  output logic frame_stb
);
  logic [BC_W-1:0] bc;
  logic            slot_end;

  assign slot_end = bck_fall_ev && (bc == BC_W'(slot_len(ch32) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc        <= '0;
      ws        <= 1'b0;
      frame_stb <= 1'b0;
    end else if (!run) begin
      bc        <= '0;
      ws        <= 1'b0;
      frame_stb <= 1'b0;
    end else begin
      if (bck_fall_ev) bc <= slot_end ? '0 : bc + 1'b1;
      if (slot_end)    ws <= ~ws;
      frame_stb <= slot_end && ws;
    end
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import acg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_val,
  input  logic             odd_ext,
  input  logic             mclk_en,
  input  logic             ch32,
  output logic             mclk,
  output logic             bclk,
  output logic             ws,
  output logic             frame_pulse,
  output logic             cfg_err
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] ratio_q;
  logic             mck_q;
  logic             ch_q;
  logic             lin;
  logic             lin_rise;
  logic             lin_fall;
  logic             bck_fall_ev;

  // Configuration is sampled only while disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= CNT_W'(2);
      mck_q   <= 1'b0;
      ch_q    <= 1'b0;
      cfg_err <= 1'b0;
    end else if (!enable) begin
      ratio_q <= CNT_W'(eff_ratio(int'(div_val), odd_ext));
      mck_q   <= mclk_en;
      ch_q    <= ch32;
      cfg_err <= ratio_bad(int'(div_val));
    end
  end

  acg_lindiv #(.CNT_W(CNT_W)) u_lin (
    .clk(clk), .rst_n(rst_n), .run(enable), .ratio(ratio_q),
    .lin(lin), .rise_ev(lin_rise), .fall_ev(lin_fall)
  );

  acg_bitdiv u_bit (
    .clk(clk), .rst_n(rst_n), .run(enable), .mck_mode(mck_q), .ch32(ch_q),
    .lin_rise(lin_rise), .lin_fall(lin_fall), .bck(bclk), .bck_fall_ev(bck_fall_ev)
  );

  acg_framer u_frm (
    .clk(clk), .rst_n(rst_n), .run(enable), .ch32(ch_q),
    .bck_fall_ev(bck_fall_ev), .ws(ws), .frame_stb(frame_pulse)
  );

  assign mclk = lin & mck_q;
endmodule

// File: rtl/acg_checker.sv
module acg_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic mck_on,
  input logic mclk,
  input logic bclk,
  input logic ws,
  input logic frame_pulse
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!mclk && !bclk && !ws && !frame_pulse)); // R10

  AST_WS_ON_BCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(ws)) |-> $fell(bclk)); // R7

  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> !frame_pulse); // R8

  AST_FS_AT_WS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> $fell(ws)); // R8

  AST_BCK_ON_MCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && mck_on && !$stable(bclk)) |-> $fell(mclk)); // R4
endmodule

bind audio_clkgen acg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mck_on(mck_q),
  .mclk(mclk), .bclk(bclk), .ws(ws), .frame_pulse(frame_pulse)
);

// File: tb/audio_clkgen_tb.sv
`timescale 1ns/1ps
module audio_clkgen_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       enable = 0;
  logic [7:0] div_val = 8'd3;
  logic       odd_ext = 0;
  logic       mclk_en = 0;
  logic       ch32 = 0;
  logic       mclk, bclk, ws, frame_pulse, cfg_err;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  audio_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_val(div_val), .odd_ext(odd_ext),
    .mclk_en(mclk_en), .ch32(ch32), .mclk(mclk), .bclk(bclk), .ws(ws),
    .frame_pulse(frame_pulse), .cfg_err(cfg_err)
  );

  // Edge monitor, sampled at the falling kernel edge.
  int  cyc = 0;
  bit  clr = 0;
  int  t_br, b_per, b_hi, t_mr, m_per, m_hi, m_rises, t_wr, w_hi, t_fs, f_per, ws_bad, fs_bad;
  bit  p_b, p_m, p_w, p_f;

  always @(negedge clk) begin
    cyc++;
    if (clr) begin
      t_br = -1; b_per = 0; b_hi = 0; t_mr = -1; m_per = 0; m_hi = 0; m_rises = 0;
      t_wr = -1; w_hi = 0; t_fs = -1; f_per = 0; ws_bad = 0; fs_bad = 0;
    end else begin
      if (bclk && !p_b) begin if (t_br >= 0) b_per = cyc - t_br; t_br = cyc; end
      if (!bclk && p_b && t_br >= 0) b_hi = cyc - t_br;
      if (mclk && !p_m) begin m_rises++; if (t_mr >= 0) m_per = cyc - t_mr; t_mr = cyc; end
      if (!mclk && p_m && t_mr >= 0) m_hi = cyc - t_mr;
      if (ws && !p_w) t_wr = cyc;
      if (!ws && p_w && t_wr >= 0) w_hi = cyc - t_wr;
      if (ws != p_w && !(p_b && !bclk)) ws_bad++;
      if (frame_pulse) begin
        if (p_f || !(p_w && !ws)) fs_bad++;
        if (t_fs >= 0) f_per = cyc - t_fs;
        t_fs = cyc;
      end
    end
    p_b = bclk; p_m = mclk; p_w = ws; p_f = frame_pulse;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input int d, input bit o, input bit m, input bit c);
    @(negedge clk);
    enable = 0; div_val = 8'(d); odd_ext = o; mclk_en = m; ch32 = c;
    repeat (3) @(negedge clk);
    check("R10 idle low", {mclk, bclk, ws, frame_pulse}, 0);
    clr = 1;
    @(negedge clk);
    clr = 0;
    enable = 1;
    repeat (2) @(negedge clk);
    check("R10 left slot first", ws, 0);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    check("R11 reset outputs", {mclk, bclk, ws, frame_pulse, cfg_err}, 0);
    rst_n = 1;
  endtask

  task automatic t_even16();
    start(3, 0, 0, 0);
    repeat (500) @(negedge clk);
    check("R1 bclk period N=6", b_per, 6);
    check("R2 bclk high even", b_hi, 3);
    check("R5 mclk held low", m_rises, 0);
    check("R6 ws high 16 bits", w_hi, 16 * 6);
    check("R8 frame period", f_per, 32 * 6);
    check("R7 ws on bclk fall", ws_bad, 0);
    check("R8 strobe shape", fs_bad, 0);
    check("R3 legal no error", cfg_err, 0);
  endtask

  task automatic t_odd32();
    start(3, 1, 0, 1);
    repeat (1100) @(negedge clk);
    check("R1 bclk period N=7", b_per, 7);
    check("R2 odd high phase", b_hi, 4);
    check("R6 ws high 32 bits", w_hi, 32 * 7);
    check("R8 frame period 32", f_per, 64 * 7);
    check("R7 ws on bclk fall", ws_bad, 0);
  endtask

  task automatic t_mck(input bit c);
    start(2, 0, 1, c);
    repeat (2600) @(negedge clk);
    check("R4 mclk period", m_per, 4);
    check("R4 mclk high", m_hi, 2);
    check("R4 bclk post-divide", b_per, c ? 16 : 32);
    check("R8 frame 256 mclk", f_per, 1024);
    check("R6 ws slot length", w_hi, c ? 512 : 512);
    check("R8 strobe shape", fs_bad, 0);
  endtask

  task automatic t_illegal(input int d);
    start(d, 1, 0, 0);
    repeat (100) @(negedge clk);
    check("R3 clamp ratio 2", b_per, 2);
    check("R3 error flag", cfg_err, 1);
  endtask

  task automatic t_freeze();
    start(3, 0, 0, 0);
    repeat (20) @(negedge clk);
    div_val = 8'd5; odd_ext = 1; mclk_en = 1; ch32 = 1;
    repeat (500) @(negedge clk);
    check("R9 period held", b_per, 6);
    check("R9 frame held", f_per, 192);
    check("R9 mclk stays off", m_rises, 0);
    check("R9 error flag held", cfg_err, 0);
  endtask

  bit done = 0;
  initial begin
    t_reset();
    t_even16();
    t_odd32();
    t_mck(0);
    t_mck(1);
    t_illegal(0);
    t_illegal(1);
    t_freeze();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule